// File: doc/BRIEF.md
# Two-wire register port slave

This block is a serial slave on a two-wire bus: one clock line and one open-drain data line. Through it, a host reads and writes a register file addressed by 8 bits. Both bus lines are sampled with the fast system clock after a synchronizer. Edge events are decoded from the sampled lines. A state machine handles the rest of the protocol: it recognises a device address, loads a register pointer, moves data bytes in either direction and acknowledges bytes.

A strap input picks one of two device identities. The pointer advances after every data byte. From the last accessible register it wraps back to zero, so one burst can cover the whole file. A read is made in three steps: the master writes the register address, issues a repeated START, then sends the read-mode device address.

The register storage sits inside the block. The rest of the chip can read it at any time through a parallel, combinational port.

Top module: `twr_port_slave`

## Requirements
- R1: A START (data falling while the clock is high) in any state abandons the byte in progress, writes nothing from it, releases the data line and begins address recognition.
- R2: A STOP (data rising while the clock is high) releases the data line. Until the next START, clock pulses get no acknowledge and change no register.
- R3: The expected device address byte is 1,1,1,0,1, then the inverted strap, then the strap, then the direction bit in bit 0 (0 = write, 1 = read). With the strap at 0 this gives ECh to write and EDh to read; with the strap at 1 it gives EAh and EBh. A match is acknowledged by pulling the data line low during the ninth clock.
- R4: A device address byte that does not match is not acknowledged. The following bytes are then ignored until a START.
- R5: The byte after a write-mode device address is acknowledged and loaded into the register pointer.
- R6: Each later data byte is acknowledged and stored at the pointer. It then appears on the parallel read port at that address.
- R7: The pointer advances after each data byte, in both directions. From the last accessible address (parameter, default 7Fh) it wraps to 00h.
- R8: A data byte written to an address above the last accessible one is acknowledged but not stored. The parallel port and serial reads return 00h for such addresses.
- R9: After a read-mode device address, the register at the pointer is shifted out most significant bit first. Each bit is driven while the clock is low and is held through the high phase.
- R10: When the master does not acknowledge a byte the slave sent, the slave releases the data line and stays released until the next START.
- R11: The data output only pulls low or releases. It is released after reset. It changes only while the sampled clock is low, except when a START or STOP releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; sampling is at least 16 times the bus bit rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_as | input | 1 | Static strap selecting the device identity |
| par_addr | input | 8 | Parallel read port address |
| par_data | output | 8 | Register contents at par_addr, 00h above the last address |

## Verification
Every bus edge passes through two synchronizer flops and an edge-detect register. The data output is registered one cycle after the edge is detected. So an acknowledge or a read bit appears about four system clocks after the bus clock falls, and a write lands one clock after the eighth falling edge is seen. The bench master holds each bus phase for 20 system clocks and samples the data line at the middle of the high phase, well after the output has settled. Parallel-port results are read two clocks after the address is set, once the transfer has ended. Expected values are queued by the driving tasks at the time of stimulus. A monitor compares them in order against observed values.

// File: rtl/twr_pkg.sv
package twr_pkg;

    localparam int BYTE_W = 8;
    localparam logic [4:0] DEV_PREFIX = 5'b11101;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_REG,
        ST_WR,
        ST_ACK,
        ST_RD,
        ST_MACK
    } twr_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } twr_bus_t;

    function automatic logic [6:0] dev_id(input logic strap);
        return {DEV_PREFIX, ~strap, strap};
    endfunction

    function automatic logic [7:0] ptr_next(input logic [7:0] p, input logic [7:0] last);
        return (p >= last) ? 8'h00 : p + 8'h01;
    endfunction

endpackage

// File: rtl/twr_sync.sv
module twr_sync
    import twr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output twr_bus_t bus
);
    localparam int LINES = 2;

    logic [LINES-1:0] pins;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign pins = {scl_i, sda_i};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], pins[g]};
            end
            assign synced[g] = chain[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    // index 1 = clock line, index 0 = data line
    assign bus.scl   = synced[1];
    assign bus.sda   = synced[0];
    assign bus.start = synced[1] & prev[1] & prev[0] & ~synced[0];
    assign bus.stop  = synced[1] & prev[1] & ~prev[0] & synced[0];
    assign bus.rise  = synced[1] & ~prev[1];
    assign bus.fall  = ~synced[1] & prev[1];

endmodule

// File: rtl/twr_regfile.sv
module twr_regfile
    import twr_pkg::*;
#(
    parameter logic [7:0] LAST_ADDR = 8'h7F
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [7:0]  waddr,
    input  logic [7:0]  wdata,
    input  logic [7:0]  raddr_a,
    output logic [7:0]  rdata_a,
    input  logic [7:0]  raddr_b,
    output logic [7:0]  rdata_b
);
    localparam int DEPTH = int'(LAST_ADDR) + 1;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && (waddr <= LAST_ADDR)) begin
            mem[waddr[IDX_W-1:0]] <= wdata;
        end
    end

    assign rdata_a = (raddr_a <= LAST_ADDR) ? mem[raddr_a[IDX_W-1:0]] : '0;
    assign rdata_b = (raddr_b <= LAST_ADDR) ? mem[raddr_b[IDX_W-1:0]] : '0;

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        we |-> (waddr <= LAST_ADDR)); // R8

endmodule

// File: rtl/twr_engine.sv
module twr_engine
    import twr_pkg::*;
#(
    parameter logic [7:0] LAST_ADDR = 8'h7F
) (
    input  logic        clk,
    input  logic        rst,
    input  twr_bus_t    bus,
    input  logic        strap_as,
    input  logic [7:0]  rd_data,
    output logic [7:0]  rd_addr,
    output logic        we,
    output logic [7:0]  waddr,
    output logic [7:0]  wdata,
    output logic        sda_oe
);
    localparam logic [3:0] BITS = 4'(BYTE_W);

    twr_state_e  state, ack_next;
    logic [3:0]  cnt;
    logic [7:0]  shreg, txd, ptr;
    logic        mack, oe;

    assign rd_addr = ptr;
    assign waddr   = ptr;
    assign wdata   = shreg;
    assign sda_oe  = oe;
    assign we      = (state == ST_WR) && bus.fall && (cnt == BITS) && (ptr <= LAST_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ack_next <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            txd      <= '0;
            ptr      <= '0;
            mack     <= 1'b0;
            oe       <= 1'b0;
        end else if (bus.start) begin
            state <= ST_DEV;
            cnt   <= '0;
            oe    <= 1'b0;
        end else if (bus.stop) begin
            state <= ST_IDLE;
            cnt   <= '0;
            oe    <= 1'b0;
        end else begin
            unique case (state)
                ST_DEV, ST_REG, ST_WR: begin
                    if (bus.rise && cnt < BITS) begin
                        shreg <= {shreg[6:0], bus.sda};
                        cnt   <= cnt + 4'd1;
                    end else if (bus.fall && cnt == BITS) begin
                        cnt <= '0;
                        if (state == ST_DEV) begin
                            if (shreg[7:1] == dev_id(strap_as)) begin
                                oe       <= 1'b1;
                                state    <= ST_ACK;
                                ack_next <= shreg[0] ? ST_RD : ST_REG;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_REG) begin
                            ptr      <= shreg;
                            oe       <= 1'b1;
                            state    <= ST_ACK;
                            ack_next <= ST_WR;
                        end else begin
                            ptr      <= ptr_next(ptr, LAST_ADDR);
                            oe       <= 1'b1;
                            state    <= ST_ACK;
                            ack_next <= ST_WR;
                        end
                    end
                end
                ST_ACK: begin
                    if (bus.fall) begin
                        state <= ack_next;
                        cnt   <= '0;
                        if (ack_next == ST_RD) begin
                            txd <= rd_data;
                            oe  <= ~rd_data[7];
                            ptr <= ptr_next(ptr, LAST_ADDR);
                        end else begin
                            oe <= 1'b0;
                        end
                    end
                end
                ST_RD: begin
                    if (bus.fall) begin
                        if (cnt == BITS - 4'd1) begin
                            oe    <= 1'b0;
                            cnt   <= '0;
                            state <= ST_MACK;
                        end else begin
                            txd <= {txd[6:0], 1'b0};
                            oe  <= ~txd[6];
                            cnt <= cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (bus.rise) mack <= ~bus.sda;
                    if (bus.fall) begin
                        if (mack) begin
                            txd   <= rd_data;
                            oe    <= ~rd_data[7];
                            ptr   <= ptr_next(ptr, LAST_ADDR);
                            state <= ST_RD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    cnt <= '0;
                end
            endcase
        end
    end

    AST_START_ABORTS: assert property (@(posedge clk) disable iff (rst)
        bus.start |=> (state == ST_DEV && !sda_oe)); // R1

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        bus.stop |=> (state == ST_IDLE && !sda_oe)); // R2

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe); // R4

    AST_MACK_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MACK) |-> !sda_oe); // R10

    AST_OE_CLOCK_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe) && !$past(bus.start || bus.stop)) |-> !bus.scl); // R11

endmodule

// File: rtl/twr_port_slave.sv
module twr_port_slave
    import twr_pkg::*;
#(
    parameter logic [7:0] LAST_ADDR   = 8'h7F,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       strap_as,
    input  logic [7:0] par_addr,
    output logic [7:0] par_data
);
    twr_bus_t   bus;
    logic       we;
    logic [7:0] waddr, wdata, rd_addr, rd_data;

    twr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .bus   (bus)
    );

    twr_engine #(.LAST_ADDR(LAST_ADDR)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .bus      (bus),
        .strap_as (strap_as),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .we       (we),
        .waddr    (waddr),
        .wdata    (wdata),
        .sda_oe   (sda_oe)
    );

    twr_regfile #(.LAST_ADDR(LAST_ADDR)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .raddr_a (rd_addr),
        .rdata_a (rd_data),
        .raddr_b (par_addr),
        .rdata_b (par_data)
    );

endmodule

// File: tb/twr_port_slave_tb.sv
module twr_port_slave_tb;

    localparam int Q = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       strap = 1'b0;
    logic [7:0] par_addr = 8'h00;
    wire  [7:0] par_data;
    wire        sda_oe;
    wire        sda_bus = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    twr_port_slave u_dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .strap_as (strap),
        .par_addr (par_addr),
        .par_data (par_data)
    );

    string      exp_tag [$];
    logic [7:0] exp_val [$];
    logic [7:0] obs_val [$];
    int n_cmp = 0;
    int n_bad = 0;

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic push_exp(input string tag, input logic [7:0] v);
        exp_tag.push_back(tag);
        exp_val.push_back(v);
    endtask

    // monitor: pops expected and observed items in order
    initial begin
        forever begin
            @(negedge clk);
            while (obs_val.size() > 0) begin
                logic [7:0] got;
                got = obs_val.pop_front();
                n_cmp++;
                if (exp_val.size() == 0) begin
                    n_bad++;
                    $display("FAIL unexpected result: actual %02h expected none", got);
                end else begin
                    string      t;
                    logic [7:0] e;
                    t = exp_tag.pop_front();
                    e = exp_val.pop_front();
                    if (got !== e) begin
                        n_bad++;
                        $display("FAIL %s: actual %02h expected %02h", t, got, e);
                    end
                end
            end
        end
    end

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic scl_low();
        wq(); scl_m = 1'b0; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq(); wq();
            scl_m = 1'b0;
        end
        wq();
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ack_exp, input string tag);
        logic ack_seen;
        push_exp(tag, {7'b0, ack_exp});
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq(); wq();
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        ack_seen = ~sda_bus;
        wq();
        scl_m = 1'b0;
        obs_val.push_back({7'b0, ack_seen});
    endtask

    task automatic recv_byte(input logic [7:0] exp_b, input logic m_ack, input string tag);
        logic [7:0] got;
        push_exp(tag, exp_b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl_m = 1'b1; wq();
            got[i] = sda_bus;
            wq();
            scl_m = 1'b0;
        end
        sda_m = ~m_ack; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0;
        sda_m = 1'b1;
        wq();
        obs_val.push_back(got);
    endtask

    task automatic check_par(input logic [7:0] a, input logic [7:0] e, input string tag);
        push_exp(tag, e);
        par_addr = a;
        @(negedge clk); @(negedge clk);
        obs_val.push_back(par_data);
    endtask

    task automatic check_released(input string tag);
        push_exp(tag, 8'h00);
        @(negedge clk);
        obs_val.push_back({7'b0, sda_oe});
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // reset state
        check_released("R11 released after reset");
        check_par(8'h00, 8'h00, "R6 storage cleared by reset");

        // write burst, strap 0
        bus_start();
        send_byte(8'hEC, 1'b1, "R3 ack write address ECh");
        send_byte(8'h10, 1'b1, "R5 ack register address");
        send_byte(8'hA5, 1'b1, "R6 ack data 1");
        send_byte(8'h3C, 1'b1, "R6 ack data 2");
        bus_stop();
        check_released("R2 released after STOP");
        check_par(8'h10, 8'hA5, "R6 stored at 10h");
        check_par(8'h11, 8'h3C, "R7 stored at incremented 11h");

        // read back with repeated START
        bus_start();
        send_byte(8'hEC, 1'b1, "R3 ack ECh before read");
        send_byte(8'h10, 1'b1, "R5 ack read pointer");
        bus_start();
        send_byte(8'hED, 1'b1, "R3 ack read address EDh");
        recv_byte(8'hA5, 1'b1, "R9 read byte at 10h");
        recv_byte(8'h3C, 1'b0, "R9 read byte at 11h");
        check_released("R10 released after master NACK");
        bus_stop();

        // wrap on write
        bus_start();
        send_byte(8'hEC, 1'b1, "R3 ack ECh");
        send_byte(8'h7F, 1'b1, "R5 ack pointer 7Fh");
        send_byte(8'h11, 1'b1, "R6 ack data at 7Fh");
        send_byte(8'h22, 1'b1, "R7 ack data after wrap");
        bus_stop();
        check_par(8'h7F, 8'h11, "R7 stored at 7Fh");
        check_par(8'h00, 8'h22, "R7 wrapped to 00h");

        // beyond last address
        bus_start();
        send_byte(8'hEC, 1'b1, "R3 ack ECh");
        send_byte(8'h80, 1'b1, "R5 ack pointer 80h");
        send_byte(8'h99, 1'b1, "R8 ack data beyond last");
        bus_stop();
        check_par(8'h80, 8'h00, "R8 parallel read beyond last");
        check_par(8'h00, 8'h22, "R8 no alias into 00h");
        bus_start();
        send_byte(8'hEC, 1'b1, "R3 ack ECh");
        send_byte(8'h80, 1'b1, "R5 ack pointer 80h");
        bus_start();
        send_byte(8'hED, 1'b1, "R3 ack EDh");
        recv_byte(8'h00, 1'b0, "R8 serial read beyond last");
        bus_stop();

        // mismatching address
        bus_start();
        send_byte(8'hE8, 1'b0, "R4 no ack for E8h");
        send_byte(8'h00, 1'b0, "R4 ignored pointer byte");
        send_byte(8'h55, 1'b0, "R4 ignored data byte");
        bus_stop();
        check_par(8'h00, 8'h22, "R4 register unchanged");

        // strap high
        strap = 1'b1;
        bus_start();
        send_byte(8'hEC, 1'b0, "R4 ECh rejected with strap high");
        bus_stop();
        bus_start();
        send_byte(8'hEA, 1'b1, "R3 ack EAh");
        send_byte(8'h05, 1'b1, "R5 ack pointer 05h");
        send_byte(8'h66, 1'b1, "R6 ack data at 05h");
        bus_stop();
        bus_start();
        send_byte(8'hEA, 1'b1, "R3 ack EAh");
        send_byte(8'h05, 1'b1, "R5 ack pointer 05h");
        bus_start();
        send_byte(8'hEB, 1'b1, "R3 ack EBh");
        recv_byte(8'h66, 1'b0, "R9 read 05h with strap high");
        bus_stop();

        // abort a data byte with START
        bus_start();
        send_byte(8'hEA, 1'b1, "R3 ack EAh");
        send_byte(8'h20, 1'b1, "R5 ack pointer 20h");
        send_bits(8'hFF, 4);
        bus_start();
        send_byte(8'hEB, 1'b1, "R1 ack after START abort");
        recv_byte(8'h00, 1'b0, "R1 aborted byte not stored");
        bus_stop();
        check_par(8'h20, 8'h00, "R1 parallel view of 20h");

        // clocks after STOP are ignored
        bus_start();
        send_byte(8'hEA, 1'b1, "R3 ack EAh");
        send_byte(8'h30, 1'b1, "R5 ack pointer 30h");
        bus_stop();
        scl_low();
        send_byte(8'h77, 1'b0, "R2 no ack without START");
        wq();
        scl_m = 1'b1; wq();
        check_par(8'h30, 8'h00, "R2 no write without START");

        // read across the wrap
        bus_start();
        send_byte(8'hEA, 1'b1, "R3 ack EAh");
        send_byte(8'h7F, 1'b1, "R5 ack pointer 7Fh");
        bus_start();
        send_byte(8'hEB, 1'b1, "R3 ack EBh");
        recv_byte(8'h11, 1'b1, "R9 read 7Fh");
        recv_byte(8'h22, 1'b0, "R7 read wraps to 00h");
        bus_stop();

        repeat (10) @(negedge clk);
        if (exp_val.size() != 0) begin
            n_bad++;
            $display("FAIL drain: actual %0d pending expected 0", exp_val.size());
        end
        summary();
        $finish;
    end

endmodule